// File: doc/BRIEF.md
# CAN Control Register with Message Timestamp Timer

This block holds the first control and status byte of a CAN controller and the 16-bit timer that stamps messages. The CPU reads the byte and writes it through a single-cycle register port. Three status inputs from the receiver front end set or show bits in the byte. Two of them (receiving active and bus synchronized) are shown live. The third, a valid-frame pulse, sets a sticky flag that software clears by writing 1 to it.

When the timer enable bit is set, a free-running counter advances on every bit-rate tick. When the end-of-frame strobe of a valid message arrives while the timer runs, the block captures the counter. In the next cycle it presents that value with a buffer write strobe. The strobe comes with the offset of the top two bytes of the active message buffer: the high byte goes to offset 0x0E and the low byte to 0x0F.

An initialization-request bit locks the byte. While that bit is set, only the bit itself can be written, and the timer is held off and at zero.

Top module: `canctl_tstamp`

## Requirements
- R1: After reset the read byte is 0x01 with both status inputs low: initialization request set, every other stored bit clear. The timer reads 0, the stamp strobe is low and the initialization-mode output is high.
- R2: A one-cycle valid-frame pulse sets bit 7 of the read byte at the next clock edge. The bit then stays set with no further pulse.
- R3: Outside initialization mode, writing a byte with bit 7 = 1 clears the received-frame flag. Writing bit 7 = 0 leaves the flag unchanged.
- R4: When a valid-frame pulse and a clearing write fall in the same cycle, the flag ends up set.
- R5: Bit 6 shows the receiving-active input and bit 4 shows the synchronized input. Write data on those two positions has no effect.
- R6: In initialization mode a write changes only bit 0, the initialization request. Bits 5 (stop in wait), 2 (wake-up enable), 1 (sleep request) and 3 (timer enable) keep their values.
- R7: Bit 3, timer enable, reads 0 whenever initialization mode is active. A write that sets bit 0 clears bit 3 in the same cycle.
- R8: With the timer enabled, the timer output rises by exactly one per clock that carries a bit-rate tick and holds otherwise. It wraps from 0xFFFF to 0x0000.
- R9: With the timer disabled, the timer output reads 0.
- R10: An end-of-frame strobe in a cycle where the timer is enabled raises the stamp strobe for one cycle, in the next cycle. In that cycle the stamp output carries the timer value from the strobe cycle, and the buffer offset output reads 0x0E (high byte; the low byte goes to 0x0F). With the timer disabled, no stamp strobe appears.
- R11: The initialization-mode output equals bit 0 of the read byte. Writing bit 0 = 1 enters initialization mode and writing 0 leaves it, in any mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_i | input | 1 | CPU write strobe for the control byte |
| reg_wdata_i | input | 8 | CPU write data |
| reg_rdata_o | output | 8 | Control byte as read by the CPU |
| init_mode_o | output | 1 | Initialization mode active |
| rx_busy_i | input | 1 | Receiver front end is receiving a message |
| bus_sync_i | input | 1 | Controller is synchronized to the bus |
| frame_ok_i | input | 1 | Pulse: valid message received |
| eof_i | input | 1 | Pulse: end of frame of a valid sent or received message |
| bit_tick_i | input | 1 | One pulse per bus bit time |
| timer_o | output | TS_W | Live timestamp counter |
| stamp_o | output | TS_W | Captured timestamp for the message buffer |
| stamp_wr_o | output | 1 | Buffer write strobe for the timestamp |
| stamp_addr_o | output | BUF_AW | Buffer offset of the timestamp high byte |

## Verification
Two pairs of events can land on the same clock edge. The first pair is a valid-frame pulse and a CPU write that clears the flag. The bench drives both in one cycle and expects the flag set afterwards. It then checks that a later lone clearing write does clear the flag. The second pair is an end-of-frame strobe and a bit-rate tick. Here the stamp must carry the count from before that tick, while the live timer already shows the incremented value. A reference model in the bench, built only from the requirements, predicts both outcomes.

// File: rtl/canctl_pkg.sv
package canctl_pkg;

  localparam int unsigned CTL_W = 8;

  // Bit positions of the control byte (read by software, so fixed)
  localparam int unsigned B_RXFRM    = 7;
  localparam int unsigned B_RXBUSY   = 6;
  localparam int unsigned B_STOPWAIT = 5;
  localparam int unsigned B_SYNC     = 4;
  localparam int unsigned B_TMREN    = 3;
  localparam int unsigned B_WAKEEN   = 2;
  localparam int unsigned B_SLPREQ   = 1;
  localparam int unsigned B_INITREQ  = 0;

  typedef struct packed {
    logic stop_wait;
    logic wake_en;
    logic slp_req;
    logic init_req;
  } ctl_cfg_t;

  localparam ctl_cfg_t CFG_RST = '{stop_wait: 1'b0, wake_en: 1'b0,
                                   slp_req: 1'b0, init_req: 1'b1};

endpackage

// File: rtl/canctl_cfgbits.sv
module canctl_cfgbits
  import canctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [CTL_W-1:0] wdata_i,
  output ctl_cfg_t         cfg_o,
  output logic             tmr_en_o,
  output logic             tmr_en_nx_o,
  output logic             wr_open_o
);

  ctl_cfg_t cfg_q, cfg_d;
  logic     ten_q, ten_d;
  logic     open_w;
  logic     cfg_ce;

  // Next state: the byte is open to writes only outside init mode,
  // except the init request itself.
  always_comb begin
    open_w = wr_i & ~cfg_q.init_req;
    cfg_ce = wr_i;
    cfg_d  = cfg_q;
    ten_d  = ten_q;
    if (open_w) begin
      cfg_d.stop_wait = wdata_i[B_STOPWAIT];
      cfg_d.wake_en   = wdata_i[B_WAKEEN];
      cfg_d.slp_req   = wdata_i[B_SLPREQ];
      ten_d           = wdata_i[B_TMREN];
    end
    if (wr_i) begin
      cfg_d.init_req = wdata_i[B_INITREQ];
    end
    // Timer enable is held low during init mode and on entry to it
    if (cfg_q.init_req || cfg_d.init_req) begin
      ten_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= CFG_RST;
      ten_q <= 1'b0;
    end else if (cfg_ce) begin
      cfg_q <= cfg_d;
      ten_q <= ten_d;
    end
  end

  assign cfg_o       = cfg_q;
  assign tmr_en_o    = ten_q;
  assign tmr_en_nx_o = cfg_ce ? ten_d : ten_q;
  assign wr_open_o   = open_w;

endmodule

// File: rtl/canctl_rxflag.sv
module canctl_rxflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  logic flag_q, flag_d, flag_ce;

  // A set in the same cycle as a clear wins: no reception is lost
  always_comb begin
    flag_ce = set_i | clr_i;
    flag_d  = set_i ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else if (flag_ce) begin
      flag_q <= flag_d;
    end
  end

  assign flag_o = flag_q;

endmodule

// File: rtl/canctl_stamp_timer.sv
module canctl_stamp_timer #(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned BUF_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic              en_nx_i,
  input  logic              tick_i,
  input  logic              eof_i,
  output logic [TS_W-1:0]   timer_o,
  output logic [TS_W-1:0]   stamp_o,
  output logic              stamp_wr_o,
  output logic [BUF_AW-1:0] stamp_addr_o
);

  // High byte of the stamp sits two below the top of the buffer
  localparam int unsigned    TOP_OFS = (1 << BUF_AW) - 2;
  localparam logic [BUF_AW-1:0] HI_OFS = TOP_OFS[BUF_AW-1:0];

  logic [TS_W-1:0]   tmr_q, tmr_d;
  logic              tmr_ce;
  logic [TS_W-1:0]   stamp_q, stamp_d;
  logic              swr_q, swr_d;
  logic [BUF_AW-1:0] sadr_q, sadr_d;
  logic              cap;

  always_comb begin
    tmr_ce = tick_i | ~en_nx_i;
    if (!en_nx_i) begin
      tmr_d = '0;
    end else begin
      tmr_d = tmr_q + 1'b1;
    end
  end

  always_comb begin
    cap     = eof_i & en_i;
    swr_d   = cap;
    stamp_d = cap ? tmr_q : stamp_q;
    sadr_d  = cap ? HI_OFS : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr_q <= '0;
    end else if (tmr_ce) begin
      tmr_q <= tmr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stamp_q <= '0;
      swr_q   <= 1'b0;
      sadr_q  <= '0;
    end else begin
      stamp_q <= stamp_d;
      swr_q   <= swr_d;
      sadr_q  <= sadr_d;
    end
  end

  assign timer_o      = tmr_q;
  assign stamp_o      = stamp_q;
  assign stamp_wr_o   = swr_q;
  assign stamp_addr_o = sadr_q;

endmodule

// File: rtl/canctl_tstamp.sv
module canctl_tstamp
  import canctl_pkg::*;
#(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned BUF_AW = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [CTL_W-1:0]  reg_wdata_i,
  output logic [CTL_W-1:0]  reg_rdata_o,
  output logic              init_mode_o,
  input  logic              rx_busy_i,
  input  logic              bus_sync_i,
  input  logic              frame_ok_i,
  input  logic              eof_i,
  input  logic              bit_tick_i,
  output logic [TS_W-1:0]   timer_o,
  output logic [TS_W-1:0]   stamp_o,
  output logic              stamp_wr_o,
  output logic [BUF_AW-1:0] stamp_addr_o
);

  ctl_cfg_t cfg;
  logic     ten, ten_nx, wr_open;
  logic     rxfrm;

  canctl_cfgbits u_cfg (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_i        (reg_wr_i),
    .wdata_i     (reg_wdata_i),
    .cfg_o       (cfg),
    .tmr_en_o    (ten),
    .tmr_en_nx_o (ten_nx),
    .wr_open_o   (wr_open)
  );

  canctl_rxflag u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (frame_ok_i),
    .clr_i  (wr_open & reg_wdata_i[B_RXFRM]),
    .flag_o (rxfrm)
  );

  canctl_stamp_timer #(
    .TS_W   (TS_W),
    .BUF_AW (BUF_AW)
  ) u_tmr (
    .clk          (clk),
    .rst_n        (rst_n),
    .en_i         (ten),
    .en_nx_i      (ten_nx),
    .tick_i       (bit_tick_i),
    .eof_i        (eof_i),
    .timer_o      (timer_o),
    .stamp_o      (stamp_o),
    .stamp_wr_o   (stamp_wr_o),
    .stamp_addr_o (stamp_addr_o)
  );

  always_comb begin
    reg_rdata_o             = '0;
    reg_rdata_o[B_RXFRM]    = rxfrm;
    reg_rdata_o[B_RXBUSY]   = rx_busy_i;
    reg_rdata_o[B_STOPWAIT] = cfg.stop_wait;
    reg_rdata_o[B_SYNC]     = bus_sync_i;
    reg_rdata_o[B_TMREN]    = ten;
    reg_rdata_o[B_WAKEEN]   = cfg.wake_en;
    reg_rdata_o[B_SLPREQ]   = cfg.slp_req;
    reg_rdata_o[B_INITREQ]  = cfg.init_req;
  end

  assign init_mode_o = cfg.init_req;

endmodule

// File: rtl/canctl_tstamp_chk.sv
module canctl_tstamp_chk #(
  parameter int unsigned TS_W   = 16,
  parameter int unsigned BUF_AW = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr,
  input logic              wclr,
  input logic              init,
  input logic              flag,
  input logic              ten,
  input logic [2:0]        cfgb,
  input logic              frame_ok,
  input logic              eof,
  input logic              tick,
  input logic [TS_W-1:0]   timer,
  input logic              swr,
  input logic [BUF_AW-1:0] sadr
);

  localparam int unsigned       TOP_OFS = (1 << BUF_AW) - 2;
  localparam logic [BUF_AW-1:0] HI_OFS  = TOP_OFS[BUF_AW-1:0];

  a_r2_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> flag);

  a_r3_keep_without_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !(wr && wclr && !init)) |=> flag);

  a_r4_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_ok && wr && wclr) |=> flag);

  a_r6_locked_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    init |=> $stable(cfgb));

  a_r7_ten_low_in_init: assert property (@(posedge clk) disable iff (!rst_n)
    init |-> !ten);

  a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    (ten && tick) |=> (!ten || timer == TS_W'($past(timer) + 1'b1)));

  a_r9_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ten |-> timer == '0);

  a_r10_stamp_origin: assert property (@(posedge clk) disable iff (!rst_n)
    swr |-> ($past(eof) && $past(ten) && sadr == HI_OFS));

endmodule

bind canctl_tstamp canctl_tstamp_chk #(
  .TS_W   (TS_W),
  .BUF_AW (BUF_AW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .wr       (reg_wr_i),
  .wclr     (reg_wdata_i[7]),
  .init     (init_mode_o),
  .flag     (reg_rdata_o[7]),
  .ten      (reg_rdata_o[3]),
  .cfgb     ({reg_rdata_o[5], reg_rdata_o[2], reg_rdata_o[1]}),
  .frame_ok (frame_ok_i),
  .eof      (eof_i),
  .tick     (bit_tick_i),
  .timer    (timer_o),
  .swr      (stamp_wr_o),
  .sadr     (stamp_addr_o)
);

// File: tb/canctl_tstamp_test.sv
module canctl_tstamp_test;

  localparam int TS_W   = 16;
  localparam int BUF_AW = 4;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr_i;
  logic [7:0]        reg_wdata_i;
  logic [7:0]        reg_rdata_o;
  logic              init_mode_o;
  logic              rx_busy_i, bus_sync_i, frame_ok_i, eof_i, bit_tick_i;
  logic [TS_W-1:0]   timer_o, stamp_o;
  logic              stamp_wr_o;
  logic [BUF_AW-1:0] stamp_addr_o;

  always #4 clk = ~clk;

  canctl_tstamp uut (
    .clk(clk), .rst_n(rst_n), .reg_wr_i(reg_wr_i), .reg_wdata_i(reg_wdata_i),
    .reg_rdata_o(reg_rdata_o), .init_mode_o(init_mode_o),
    .rx_busy_i(rx_busy_i), .bus_sync_i(bus_sync_i), .frame_ok_i(frame_ok_i),
    .eof_i(eof_i), .bit_tick_i(bit_tick_i), .timer_o(timer_o),
    .stamp_o(stamp_o), .stamp_wr_o(stamp_wr_o), .stamp_addr_o(stamp_addr_o)
  );

  // Scoreboard item kinds
  localparam int K_RD = 0, K_TMR = 1, K_SWR = 2, K_STAMP = 3, K_INIT = 4, K_ADDR = 5;

  typedef struct {
    int          kind;
    int unsigned exp;
    string       tag;
  } item_t;

  item_t q[$];
  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;

  // Reference model state
  logic        m_frm, m_cw, m_ten, m_wu, m_sl, m_in;
  logic [15:0] m_tmr;
  logic        busy_v = 1'b0, sync_v = 1'b0;

  task automatic push(input int kind, input int unsigned exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    q.push_back(it);
  endtask

  task automatic cyc(input logic wr, input logic [7:0] wd, input logic frm,
                     input logic eof, input logic tick, input string tag);
    logic open, ten_old, nin, nten;
    logic [15:0] tmr_old;
    @(negedge clk);
    reg_wr_i = wr; reg_wdata_i = wd; frame_ok_i = frm; eof_i = eof;
    bit_tick_i = tick; rx_busy_i = busy_v; bus_sync_i = sync_v;
    open    = wr && !m_in;
    ten_old = m_ten;
    tmr_old = m_tmr;
    if (frm) m_frm = 1'b1;
    else if (open && wd[7]) m_frm = 1'b0;
    nten = m_ten;
    if (open) begin
      m_cw = wd[5]; m_wu = wd[2]; m_sl = wd[1]; nten = wd[3];
    end
    nin = wr ? wd[0] : m_in;
    if (m_in || nin) nten = 1'b0;
    m_in  = nin;
    m_ten = nten;
    if (!m_ten) m_tmr = 16'h0;
    else if (tick) m_tmr = m_tmr + 16'h1;
    push(K_RD, {24'h0, m_frm, busy_v, m_cw, sync_v, m_ten, m_wu, m_sl, m_in}, tag);
    push(K_TMR, {16'h0, m_tmr}, tag);
    push(K_INIT, {31'h0, m_in}, tag);
    push(K_SWR, {31'h0, eof && ten_old}, tag);
    if (eof && ten_old) begin
      push(K_STAMP, {16'h0, tmr_old}, tag);
      push(K_ADDR, 32'hE, tag);
    end
  endtask

  // Monitor: compare after every rising edge, away from the edge
  always @(posedge clk) begin
    #2;
    while (q.size() > 0) begin
      item_t it;
      int unsigned act;
      it = q.pop_front();
      case (it.kind)
        K_RD:    act = {24'h0, reg_rdata_o};
        K_TMR:   act = {16'h0, timer_o};
        K_SWR:   act = {31'h0, stamp_wr_o};
        K_STAMP: act = {16'h0, stamp_o};
        K_INIT:  act = {31'h0, init_mode_o};
        default: act = {28'h0, stamp_addr_o};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    reg_wr_i = 1'b0; reg_wdata_i = 8'h00; frame_ok_i = 1'b0; eof_i = 1'b0;
    bit_tick_i = 1'b0; rx_busy_i = 1'b0; bus_sync_i = 1'b0;
    m_frm = 1'b0; m_cw = 1'b0; m_ten = 1'b0; m_wu = 1'b0; m_sl = 1'b0;
    m_in = 1'b1; m_tmr = 16'h0;
    repeat (2) @(negedge clk);
    // R1: reset state
    push(K_RD, 32'h01, "R1");
    push(K_TMR, 32'h0, "R1");
    push(K_SWR, 32'h0, "R1");
    push(K_INIT, 32'h1, "R1");
    @(negedge clk);
    rst_n = 1'b1;

    // R6: in init only bit 0 changes
    cyc(1'b1, 8'hAF, 1'b0, 1'b0, 1'b1, "R6");
    // R7: timer enable cannot be set by a write made in init mode
    cyc(1'b1, 8'h28, 1'b0, 1'b0, 1'b1, "R7");
    // R11: out of init, bits written normally
    cyc(1'b1, 8'h26, 1'b0, 1'b0, 1'b0, "R11");
    // R8: enable timer and count ticks
    cyc(1'b1, 8'h0E, 1'b0, 1'b0, 1'b0, "R8");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R8");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
    // R5: status bits follow inputs, writes to them ignored
    busy_v = 1'b1; sync_v = 1'b0;
    cyc(1'b1, 8'h1E, 1'b0, 1'b0, 1'b0, "R5");
    busy_v = 1'b0; sync_v = 1'b1;
    cyc(1'b1, 8'h4E, 1'b0, 1'b0, 1'b0, "R5");
    busy_v = 1'b0; sync_v = 1'b0;
    // R2: valid frame sets sticky flag
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R2");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R2");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R2");
    // R3: write 0 keeps it, write 1 clears it
    cyc(1'b1, 8'h0E, 1'b0, 1'b0, 1'b0, "R3");
    cyc(1'b1, 8'h8E, 1'b0, 1'b0, 1'b0, "R3");
    // R4: set and clear together, set wins; then lone clear works
    cyc(1'b1, 8'h8E, 1'b1, 1'b0, 1'b0, "R4");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R4");
    cyc(1'b1, 8'h8E, 1'b0, 1'b0, 1'b0, "R4");
    // R10: stamp on eof, alone and together with a tick
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R10");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R10");
    cyc(1'b0, 8'h00, 1'b1, 1'b1, 1'b1, "R10");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R10");
    // R9: disabling clears the timer
    cyc(1'b1, 8'h06, 1'b0, 1'b0, 1'b1, "R9");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R9");
    // R10: no stamp while disabled
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R10");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R10");
    // R8: wrap from 0xFFFF to 0
    cyc(1'b1, 8'h0E, 1'b0, 1'b0, 1'b0, "R8");
    for (int i = 0; i < 65535; i++) cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R8");
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, "R8");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, "R10");
    // R7: entering init drops timer enable and clears the timer
    cyc(1'b1, 8'h0F, 1'b0, 1'b0, 1'b1, "R7");
    cyc(1'b1, 8'h8F, 1'b1, 1'b0, 1'b1, "R7");
    // R3: a clearing write in init mode is not accepted
    cyc(1'b1, 8'h81, 1'b0, 1'b0, 1'b0, "R3");
    // R11: leave init mode
    cyc(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R11");
    cyc(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, "R11");
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule